// File: doc/BRIEF.md
# RC5 Key-Schedule Mixing Round

This block performs a single mixing step of the RC5 key expansion on 32-bit words. Each cycle it can take a fresh operand set: the two running words A and B, one expanded-table word S and one secret-key word L, marked by a valid strobe. Two clock cycles later it returns the updated A and B with their own valid strobe. A wider controller walks the table and key arrays, initialises them and loops over them. This block holds none of that state and runs no loop.

The new A is the wrapped sum S + A + B, rotated left by three bit positions. The new B is the wrapped sum L + newA + B, rotated left by an amount taken from the low five bits of newA + B. The first stage computes newA and the key partial sum L + B. The second stage forms the rotate amount and the final sum in parallel, then passes the result through a logarithmic barrel rotator.

Two elaboration options exist. In the first, S is a compile-time constant: the S port is ignored and the constant folds into the first adder. In the second, L is presented one cycle ahead of the operand set it belongs to, which helps a controller that reads the key array one cycle early.

Top module: `rc5mix_top`

## Requirements
- R1: For every accepted set, a_o equals (S + A + B) mod 2^32, rotated left by 3 bit positions.
- R2: For every accepted set, b_o equals (L + newA + B) mod 2^32, rotated left by the value of bits [4:0] of (newA + B) mod 2^32.
- R3: out_valid rises exactly two clock edges after in_valid is sampled high, and a_o/b_o hold that set's results while out_valid is high.
- R4: Operand sets on consecutive cycles are all accepted, and each yields its own result on consecutive output cycles.
- R5: A synchronous active-high rst clears both pipeline valid bits, so out_valid is low in the cycle after rst is sampled high and in the cycle after that.
- R6: A rotate amount of 0 leaves the pre-rotate sum unchanged, and an amount of 31 equals a rotate right by one position.
- R7: With S_CONST_EN=1, s_i has no effect on the outputs, and the parameter S_CONST_VAL is used in place of S.
- R8: With L_EARLY=1, the L of a set is the value on l_i in the cycle before that set's in_valid cycle.
- R9: All additions wrap modulo 2^32, and carries out of bit 31 are dropped (for example, all-ones operands).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand set on a_i, b_i, s_i (and l_i) is valid |
| a_i | input | 32 | Running word A |
| b_i | input | 32 | Running word B |
| s_i | input | 32 | Table word S (ignored when S_CONST_EN=1) |
| l_i | input | 32 | Key word L (one cycle early when L_EARLY=1) |
| out_valid | output | 1 | Results on a_o and b_o are valid |
| a_o | output | 32 | Updated word A |
| b_o | output | 32 | Updated word B |

## Verification
Several properties are checked on every cycle, next to the logic. The first-stage A result must match the rotated sum of the operands sampled one edge before. The early-key partial sum must use the key word from two edges back. Each valid bit must trace back to the valid one stage earlier. The barrel rotator must keep its population count, and must pass its input through when the amount is zero. Only the bench's scenarios can show the complete two-stage arithmetic against an independent model, covering all 32 rotate amounts, all-ones wraparound, back-to-back streams with gaps, a reset in mid-stream, and the fact that the S port is ignored in constant mode.

// File: rtl/rc5mix_pkg.sv
package rc5mix_pkg;

    localparam int WORD_W = 32;
    localparam int AMT_W  = $clog2(WORD_W);
    localparam int ROT_A  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [AMT_W-1:0]  amt_t;

    // state handed from the first stage to the second
    typedef struct packed {
        logic  valid;
        word_t a_new;
        word_t b;
        word_t lb;
    } front_t;

    typedef struct packed {
        logic  valid;
        word_t a;
        word_t b;
    } result_t;

    function automatic word_t rotl_fixed(input word_t x);
        return (x << ROT_A) | (x >> (WORD_W - ROT_A));
    endfunction

    function automatic word_t rotr_var(input word_t x, input amt_t n);
        return (x >> n) | (x << (WORD_W - int'(n)));
    endfunction

endpackage

// File: rtl/rc5mix_front.sv
module rc5mix_front
    import rc5mix_pkg::*;
#(
    parameter bit    S_CONST_EN  = 1'b0,
    parameter word_t S_CONST_VAL = 32'h9E37_79B9,
    parameter bit    L_EARLY     = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_i,
    input  word_t  a_i,
    input  word_t  b_i,
    input  word_t  s_i,
    input  word_t  l_i,
    output front_t q_o
);

    word_t  s_sel;
    word_t  l_sel;
    front_t q;

    generate
        if (S_CONST_EN) begin : g_s_const
            assign s_sel = S_CONST_VAL;
        end else begin : g_s_port
            assign s_sel = s_i;
        end
    endgenerate

    generate
        if (L_EARLY) begin : g_l_early
            word_t l_hold;
            always_ff @(posedge clk) begin
                l_hold <= l_i;
            end
            assign l_sel = l_hold;

            // key partial sum pairs B with the key word of the prior cycle
            p_early_key_r8: assert property (@(posedge clk) disable iff (rst)
                q.valid |-> (q.lb == $past(b_i) + $past(l_i, 2)));
        end else begin : g_l_same
            assign l_sel = l_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
        end else begin
            q.valid <= valid_i;
        end
        if (valid_i) begin
            q.a_new <= rotl_fixed(s_sel + a_i + b_i);
            q.b     <= b_i;
            q.lb    <= l_sel + b_i;
        end
    end

    assign q_o = q;

    p_newa_r1: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> ((q.a_new >> ROT_A | q.a_new << (WORD_W - ROT_A))
                     == $past(s_sel + a_i + b_i)));

    p_front_valid_r3: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> $past(valid_i));

endmodule

// File: rtl/rc5mix_barrel.sv
module rc5mix_barrel
    import rc5mix_pkg::*;
(
    input  word_t din,
    input  amt_t  amt,
    output word_t dout
);

    word_t lvl [0:AMT_W];

    assign lvl[0] = din;

    generate
        for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
            localparam int SH = 1 << k;
            assign lvl[k+1] = amt[k] ? ((lvl[k] << SH) | (lvl[k] >> (WORD_W - SH)))
                                     : lvl[k];
        end
    endgenerate

    assign dout = lvl[AMT_W];

    always_comb begin
        if (!$isunknown({din, amt})) begin
            p_rot_pop_r2: assert ($countones(dout) == $countones(din));
            if (amt == '0) begin
                p_rot_zero_r6: assert (dout == din);
            end
        end
    end

endmodule

// File: rtl/rc5mix_back.sv
module rc5mix_back
    import rc5mix_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  front_t  d_i,
    output result_t q_o
);

    word_t   amt_sum;
    word_t   pre_rot;
    word_t   rotated;
    result_t q;

    // two independent adders, both fed directly by stage-one registers
    assign amt_sum = d_i.a_new + d_i.b;
    assign pre_rot = d_i.lb + d_i.a_new;

    rc5mix_barrel u_rot (
        .din  (pre_rot),
        .amt  (amt_sum[AMT_W-1:0]),
        .dout (rotated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
        end else begin
            q.valid <= d_i.valid;
        end
        if (d_i.valid) begin
            q.a <= d_i.a_new;
            q.b <= rotated;
        end
    end

    assign q_o = q;

    p_out_valid_r3: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> $past(d_i.valid));

    p_newb_r2: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> (rotr_var(q.b, $past(amt_sum[AMT_W-1:0])) == $past(pre_rot)));

endmodule

// File: rtl/rc5mix_top.sv
module rc5mix_top
    import rc5mix_pkg::*;
#(
    parameter bit    S_CONST_EN  = 1'b0,
    parameter word_t S_CONST_VAL = 32'h9E37_79B9,
    parameter bit    L_EARLY     = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [31:0] s_i,
    input  logic [31:0] l_i,
    output logic        out_valid,
    output logic [31:0] a_o,
    output logic [31:0] b_o
);

    front_t  mid;
    result_t res;

    rc5mix_front #(
        .S_CONST_EN  (S_CONST_EN),
        .S_CONST_VAL (S_CONST_VAL),
        .L_EARLY     (L_EARLY)
    ) u_front (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .a_i     (a_i),
        .b_i     (b_i),
        .s_i     (s_i),
        .l_i     (l_i),
        .q_o     (mid)
    );

    rc5mix_back u_back (
        .clk (clk),
        .rst (rst),
        .d_i (mid),
        .q_o (res)
    );

    assign out_valid = res.valid;
    assign a_o       = res.a;
    assign b_o       = res.b;

    // a set only reaches the output if it entered two edges earlier
    p_two_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |-> $past(in_valid, 2));

endmodule

// File: tb/tb_rc5mix_top.sv
module tb_rc5mix_top;

    localparam int          NV   = 480;
    localparam logic [31:0] KS   = 32'hC3A5_0F1E;
    localparam int          MIDR = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vin = 1'b0;
    logic [31:0] a_in = '0, b_in = '0, s_in = '0, l_in = '0, l_in_k = '0, s_junk = '0;
    logic        ov,  ov_k;
    logic [31:0] ao, bo, ao_k, bo_k;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rc5mix_top dut (
        .clk(clk), .rst(rst), .in_valid(vin),
        .a_i(a_in), .b_i(b_in), .s_i(s_in), .l_i(l_in),
        .out_valid(ov), .a_o(ao), .b_o(bo)
    );

    rc5mix_top #(.S_CONST_EN(1'b1), .S_CONST_VAL(KS), .L_EARLY(1'b1)) dut_k (
        .clk(clk), .rst(rst), .in_valid(vin),
        .a_i(a_in), .b_i(b_in), .s_i(s_junk), .l_i(l_in_k),
        .out_valid(ov_k), .a_o(ao_k), .b_o(bo_k)
    );

    logic [31:0] va [0:NV+1];
    logic [31:0] vb [0:NV+1];
    logic [31:0] vs [0:NV+1];
    logic [31:0] vl [0:NV+1];
    bit          vv [0:NV+1];

    function automatic logic [31:0] m_rotl(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic int m_amt(input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] s);
        logic [31:0] na;
        na = m_rotl(s + a + b, 3);
        return int'((na + b) % 32);
    endfunction

    task automatic m_mix(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] s, input logic [31:0] l,
                         output logic [31:0] na, output logic [31:0] nb);
        logic [31:0] sh;
        na = m_rotl(s + a + b, 3);
        sh = na + b;
        nb = m_rotl(l + na + b, int'(sh % 32));
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model pipeline: e1 after first edge, e2 at outputs
    bit          e1v, e2v, e1vk, e2vk;
    logic [31:0] e1a, e1b, e2a, e2b, e1ak, e1bk, e2ak, e2bk;
    string       e1t, e2t;
    bit          rst_prev;

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int idx;
        // build vectors
        for (int i = 0; i < NV + 2; i++) begin
            va[i] = $urandom; vb[i] = $urandom; vs[i] = $urandom; vl[i] = $urandom;
            vv[i] = ($urandom % 4) != 0;
        end
        // sweep every rotate amount (R6 covers 0 and 31)
        for (int r = 0; r < 32; r++) begin
            idx = 4 + r;
            va[idx] = '0; vs[idx] = '0; vv[idx] = 1'b1;
            for (int b = 1; b < 100000; b++) begin
                if (m_amt(32'd0, b, 32'd0) == r) begin
                    vb[idx] = b;
                    break;
                end
            end
        end
        // all-ones wraparound (R9)
        va[36] = '1; vb[36] = '1; vs[36] = '1; vl[36] = '1; vv[36] = 1'b1;
        va[37] = '1; vb[37] = '1; vs[37] = '1; vl[37] = '0; vv[37] = 1'b1;
        // back-to-back stream (R4)
        for (int i = 38; i < 120; i++) vv[i] = 1'b1;

        e1v = 0; e2v = 0; e1vk = 0; e2vk = 0; rst_prev = 1'b1;
        e1a = '0; e1b = '0; e2a = '0; e2b = '0;
        e1ak = '0; e1bk = '0; e2ak = '0; e2bk = '0;
        e1t = "R3"; e2t = "R3";

        for (int n = 0; n < NV + 3; n++) begin
            @(negedge clk);
            // check outputs against model
            if (n > 0) begin
                chk(ov == e2v, rst_prev ? "R5 valid" : "R3 R4 valid", 32'(ov), 32'(e2v));
                chk(ov_k == e2vk, rst_prev ? "R5 valid k" : "R3 R8 valid k",
                    32'(ov_k), 32'(e2vk));
                if (e2v && ov) begin
                    chk(ao == e2a, {"R1 ", e2t}, ao, e2a);
                    chk(bo == e2b, {"R2 ", e2t}, bo, e2b);
                end
                if (e2vk && ov_k) begin
                    chk(ao_k == e2ak, "R7 R1 const", ao_k, e2ak);
                    chk(bo_k == e2bk, "R8 R2 early", bo_k, e2bk);
                end
            end
            // drive inputs for this cycle
            rst = (n < 3) || (n == MIDR);
            if (n < NV) begin
                vin  = vv[n];
                a_in = va[n]; b_in = vb[n]; s_in = vs[n]; l_in = vl[n];
                l_in_k = vl[n+1];
            end else begin
                vin = 1'b0;
            end
            s_junk = $urandom;
            // advance model to match next edge
            e2v = rst ? 1'b0 : e1v;  e2a = e1a;  e2b = e1b;  e2t = e1t;
            e2vk = rst ? 1'b0 : e1vk; e2ak = e1ak; e2bk = e1bk;
            e1v  = !rst && vin;
            e1vk = !rst && vin;
            if (vin) begin
                m_mix(a_in, b_in, s_in, l_in, e1a, e1b);
                m_mix(a_in, b_in, KS, vl[n], e1ak, e1bk);
                if (n >= 36 && n <= 37)
                    e1t = "R9 wrap";
                else if (m_amt(a_in, b_in, s_in) == 0)
                    e1t = "R6 amt0";
                else if (m_amt(a_in, b_in, s_in) == 31)
                    e1t = "R6 amt31";
                else
                    e1t = "R4 stream";
            end
            rst_prev = rst;
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule